// File: doc/BRIEF.md
# Non-maskable interrupt edge qualifier

This block sits between an asynchronous non-maskable interrupt pin and a processor core. It brings the pin into the system clock domain through a flop chain. It then accepts only a clean rising edge. A clean edge is one with at least `LOW_MIN` synchronized low clocks before it and at least `HIGH_MIN` synchronized high clocks after it. Each accepted edge sets one pending flag. The flag stays set until the core pulses its accept strobe.

The vector number is a parameter fixed inside the block (default 2), so the core needs no bus cycle to fetch it. The block has no mask or enable input, so nothing in the core's interrupt-enable state can hold off a request. Pulses that are too short, edges that follow too short a low interval, and a level held high for a long time all give no more than the events described here. To raise another request, the pin must first go low again for `LOW_MIN` clocks.

Top module: `nmi_qualifier`

## Requirements
- R1: After reset release `pend_o` is 0. The pin is treated as not yet qualified low, so a pin held high through reset, or low for fewer than `LOW_MIN` synchronized clocks after release, raises no request.
- R2: For a clean edge, `pend_o` rises exactly `SYNC_STAGES + HIGH_MIN` rising clock edges after the first edge that samples `nmi_i` high. With the defaults (2 + 4) that is the 6th edge, and `pend_o` is still 0 after the 5th.
- R3: A rising edge preceded by fewer than `LOW_MIN` (4) consecutive low clocks raises no request.
- R4: A high pulse lasting fewer than `HIGH_MIN` (4) clocks is discarded. A pulse of at least 4 clocks that follows at least 4 low clocks sets `pend_o`.
- R5: One qualified edge sets `pend_o` once. Keeping `nmi_i` high afterwards, for any length of time, raises no further request.
- R6: After a qualified edge, a new request needs `nmi_i` low for at least 4 clocks again. A 3-clock low dip followed by a long high raises nothing.
- R7: `pend_o` stays 1 while `ack_i` is 0. It is 0 on the cycle after `ack_i` is sampled high, unless a new edge qualifies on that same cycle.
- R8: `vec_o` always equals the parameter `VECTOR` (default 8'd2).
- R9: When a qualification and `ack_i` fall on the same clock edge, the new request wins and `pend_o` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Interrupt pin, active high, asynchronous |
| ack_i | input | 1 | Core accept strobe, clears the pending flag |
| pend_o | output | 1 | Request pending for the core |
| vec_o | output | VEC_W (8) | Fixed vector number |

## Verification
The assertions assume that `ack_i` is synchronous to `clk_i`. They also assume that the only path from `nmi_i` into the qualifier is the flop chain, so every property is stated on the synchronized level and not on the raw pin. The stimulus drives both inputs only on falling clock edges, and holds each level for a whole number of clocks. Because of this, every synchronized run length equals the run length driven, and the expected value for each combination of low run and high run can be worked out directly by counting clocks.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_LOW_MIN     = 4;
  localparam int unsigned DEF_HIGH_MIN    = 4;

  function automatic int unsigned cnt_width(int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nmi_run_counter.sv
module nmi_run_counter #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned CW   = nmi_pkg::cnt_width(LIMIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == TOP);

  // saturation keeps the run length inside its range
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
endmodule

// File: rtl/nmi_qualifier.sv
module nmi_qualifier
  import nmi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned LOW_MIN     = DEF_LOW_MIN,
  parameter int unsigned HIGH_MIN    = DEF_HIGH_MIN,
  parameter int unsigned VEC_W       = 8,
  parameter logic [VEC_W-1:0] VECTOR = VEC_W'(2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned LCW = cnt_width(LOW_MIN);
  localparam int unsigned HCW = cnt_width(HIGH_MIN);
  localparam logic [HCW-1:0] HI_LAST = HCW'(HIGH_MIN - 1);

  logic           lvl;
  logic [LCW-1:0] lo_cnt;
  logic           lo_full;
  logic [HCW-1:0] hi_cnt;
  logic           hi_full;
  logic           edge_ok, tracking, qual;
  logic           track_q, pend_q;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nmi_i),
    .q_o   (lvl)
  );

  // consecutive synchronized low clocks
  nmi_run_counter #(.LIMIT(LOW_MIN)) u_lo_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (lvl),
    .inc_i (~lvl),
    .cnt_o (lo_cnt),
    .full_o(lo_full)
  );

  assign edge_ok  = lvl & lo_full;
  assign tracking = edge_ok | track_q;

  // high clocks of a run that began on a qualified-low edge
  nmi_run_counter #(.LIMIT(HIGH_MIN)) u_hi_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~lvl),
    .inc_i (lvl & tracking),
    .cnt_o (hi_cnt),
    .full_o(hi_full)
  );

  assign qual = lvl & tracking & (hi_cnt == HI_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      track_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      track_q <= lvl & tracking & ~qual;
      pend_q  <= qual | (pend_q & ~ack_i);
    end
  end

  assign pend_o = pend_q;
  assign vec_o  = VECTOR;

  p_rise_on_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(lvl) && $past(hi_cnt) == HI_LAST);
  p_qual_before_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |-> !hi_full);
  p_no_spurious_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> !$rose(pend_q));
  p_arm_needs_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_ok |-> lo_cnt == LCW'(LOW_MIN));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i |=> pend_q);
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && ack_i && !qual |=> !pend_q);
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |=> pend_q);
endmodule

// File: tb/test_nmi_qualifier.sv
module test_nmi_qualifier;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nmi_i = 1'b1;
  logic       ack_i = 1'b0;
  logic       pend_o;
  logic [7:0] vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  nmi_qualifier i_nmi_qualifier (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nmi_i (nmi_i),
    .ack_i (ack_i),
    .pend_o(pend_o),
    .vec_o (vec_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    nmi_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic accept();
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: pin high through reset and after release
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 reset state", int'(pend_o), 0);
    chk("R8 vector", int'(vec_o), 2);
    hold(1'b1, 10);
    chk("R1 high through reset", int'(pend_o), 0);

    // R1: pin low through reset, only 2 clocks low after release
    rst_ni = 1'b0;
    nmi_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    hold(1'b0, 2);
    hold(1'b1, 10);
    chk("R1 low before release", int'(pend_o), 0);

    // R2 latency, R9 coincident accept
    hold(1'b0, 6);
    hold(1'b1, 5);
    chk("R2 not before edge 6", int'(pend_o), 0);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    chk("R2 set on edge 6", int'(pend_o), 1);
    chk("R9 set wins over accept", int'(pend_o), 1);
    hold(1'b1, 5);
    chk("R7 held without accept", int'(pend_o), 1);
    accept();
    chk("R7 cleared by accept", int'(pend_o), 0);

    // R5: sustained high gives no new request
    hold(1'b1, 20);
    chk("R5 no repeat on long high", int'(pend_o), 0);

    // R6: a 3-clock dip does not re-arm, a 4-clock dip does
    hold(1'b0, 3);
    hold(1'b1, 12);
    chk("R6 short dip", int'(pend_o), 0);
    hold(1'b0, 4);
    hold(1'b1, 8);
    chk("R6 full dip", int'(pend_o), 1);
    accept();
    chk("R7 cleared again", int'(pend_o), 0);
    hold(1'b1, 4);

    // R3/R4: sweep low run and high run lengths
    for (int l = 1; l <= 6; l++) begin
      for (int h = 1; h <= 6; h++) begin
        hold(1'b0, l);
        hold(1'b1, h);
        hold(1'b0, 2);
        hold(1'b1, 6);
        if (l < 4)
          chk($sformatf("R3 low=%0d high=%0d", l, h), int'(pend_o), 0);
        else
          chk($sformatf("R4 low=%0d high=%0d", l, h), int'(pend_o), (h >= 4) ? 1 : 0);
        accept();
      end
    end

    chk("R8 vector at end", int'(vec_o), 2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule